// File: doc/BRIEF.md
# Fixed-Message Direct Trigger Controller

This block drives a 128-row message store in direct-access form. At reset it captures a 3-bit partition code and a record/play select. The code splits the store into between one and eight equal messages. Each message has its own active-low push input. After debouncing, a press on that input starts an operation on that message alone.

With the select low, every input acts as a level-held recorder. Writing advances row by row from the message's first row. It stops when the input is released or when the message's last row is done, and an end marker is then written. With the select high, every input acts as a toggle player. A falling edge starts playback and the next falling edge on the same input stops it. Playback also stops at the message's last row.

The outputs are a row address, a write strobe, a read strobe, a marker-write strobe, an active-low recording lamp and a power-down flag. The memory array and the audio path lie outside this block.

Top module: `fm_direct_ctrl`

## Requirements
- R1: The message count is the partition code plus one (code 0 gives 1 message, code 7 gives 8). Each message is floor(128 / count) rows long. Message k (1-based) starts at row (k-1) * length. Rows above count * length are never addressed.
- R2: The partition code and the select are captured on the first clock after reset. Later changes to them have no effect until the next reset.
- R3: Message input k is msg_ni[k-1], active low. A level must stay stable for DEB_CYC cycles after synchronisation before it counts. A shorter low pulse starts nothing.
- R4: With the select low, a press starts recording. wr_en_o is high and led_no is low while recording. row_o begins at the message's first row and steps up by one every ROW_CYC cycles.
- R5: Releasing the input during recording ends it. eom_wr_o pulses for one cycle with row_o at the last row written, and the block then goes idle.
- R6: If the input is still held when the message's last row completes, recording stops with the marker pulse at that last row.
- R7: With the select high, a falling edge starts playback with rd_en_o high. Reaching the message's last row ends playback, and row_o holds that row afterwards. Playback never pulses eom_wr_o.
- R8: During playback, a new falling edge on the playing message's own input stops playback.
- R9: A press on an input whose number exceeds the message count starts nothing.
- R10: If several valid inputs fall in the same cycle, the lowest-numbered one is served. Other inputs are ignored until the current operation ends.
- R11: pwr_dn_o is high exactly while idle. After reset: pwr_dn_o=1, wr_en_o=0, rd_en_o=0, eom_wr_o=0, led_no=1, row_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 3 | Partition code, captured after reset |
| sel_play_i | input | 1 | 0 = level-held record, 1 = toggle playback; captured after reset |
| msg_ni | input | 8 | Message push inputs, active low, bit k-1 is message k |
| row_o | output | 7 | Store row address |
| wr_en_o | output | 1 | Row write strobe (recording) |
| rd_en_o | output | 1 | Row read strobe (playback) |
| eom_wr_o | output | 1 | End-of-message marker write, one cycle |
| led_no | output | 1 | Recording lamp, low while recording |
| pwr_dn_o | output | 1 | High while idle |

## Verification
Some properties are checked on every cycle. At most one input is granted, and always one inside the configured count. The row only holds or steps by one during an operation and never passes the message's last row. A marker write only follows recording. The captured configuration does not move after capture. Only the bench's scenarios can show the rest: the start and end rows for each partition code, the debounce rejection of short pulses, release and toggle stops, the lowest-number priority, and that a select or code change is ignored until reset.

// File: rtl/fm_direct_pkg.sv
package fm_direct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_PLAY = 2'd2,
    ST_EOM  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/fm_debounce.sv
module fm_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic clean_no,
  output logic fall_o
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [1:0]    sync_q;
  logic          clean_q, prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      clean_q <= 1'b1;
      prev_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_ni};
      prev_q <= clean_q;
      if (sync_q[1] != clean_q) begin
        if (cnt_q == CW'(DEB_CYC - 1)) begin
          clean_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign clean_no = clean_q;
  assign fall_o   = prev_q & ~clean_q;
endmodule

// File: rtl/fm_msg_pick.sv
module fm_msg_pick #(
  parameter int NUM_MSG = 8,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MSG-1:0] fall_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_MSG-1:0] valid;
  logic [NUM_MSG-1:0] grant;

  always_comb begin
    for (int i = 0; i < NUM_MSG; i++) valid[i] = fall_i[i] && (CNT_W'(i) < cnt_i);
    hit_o = 1'b0;
    idx_o = '0;
    grant = '0;
    // lowest number wins
    for (int i = NUM_MSG - 1; i >= 0; i--) begin
      if (valid[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        grant = NUM_MSG'(1) << i;
      end
    end
  end

  assert_grant_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_grant_in_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ({1'b0, idx_o} < (IDX_W+1)'(cnt_i)));
endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import fm_direct_pkg::*;
#(
  parameter int NUM_MSG = 8,
  parameter int ROW_W   = 7,
  parameter int IDX_W   = 3,
  parameter int ROW_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  logic               play_i,
  input  logic [ROW_W:0]     len_i,
  input  logic [NUM_MSG-1:0] clean_ni,
  input  logic [NUM_MSG-1:0] fall_i,
  output logic [ROW_W-1:0]   row_o,
  output logic               wr_en_o,
  output logic               rd_en_o,
  output logic               eom_wr_o,
  output logic               led_no,
  output logic               pwr_dn_o
);
  localparam int TW = $clog2(ROW_CYC + 1);

  seq_st_e          st_q;
  logic [ROW_W-1:0] row_q, last_q;
  logic [TW-1:0]    tick_q;
  logic [IDX_W-1:0] own_q;
  logic [ROW_W:0]   first_w, last_w;
  logic             row_done, at_last;

  always_comb begin
    first_w = (ROW_W+1)'(int'(start_idx_i) * int'(len_i));
    last_w  = first_w + len_i - 1'b1;
  end

  assign row_done = (tick_q == TW'(ROW_CYC - 1));
  assign at_last  = (row_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      last_q <= '0;
      tick_q <= '0;
      own_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          own_q  <= start_idx_i;
          row_q  <= first_w[ROW_W-1:0];
          last_q <= last_w[ROW_W-1:0];
          tick_q <= '0;
          st_q   <= play_i ? ST_PLAY : ST_REC;
        end
        ST_REC: begin
          if (clean_ni[own_q]) st_q <= ST_EOM;
          else if (row_done) begin
            tick_q <= '0;
            if (at_last) st_q <= ST_EOM;
            else row_q <= row_q + 1'b1;
          end else tick_q <= tick_q + 1'b1;
        end
        ST_PLAY: begin
          if (fall_i[own_q]) st_q <= ST_IDLE;
          else if (row_done) begin
            tick_q <= '0;
            if (at_last) st_q <= ST_IDLE;
            else row_q <= row_q + 1'b1;
          end else tick_q <= tick_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign row_o    = row_q;
  assign wr_en_o  = (st_q == ST_REC);
  assign rd_en_o  = (st_q == ST_PLAY);
  assign eom_wr_o = (st_q == ST_EOM);
  assign led_no   = (st_q != ST_REC);
  assign pwr_dn_o = (st_q == ST_IDLE);

  assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_REC || st_q == ST_PLAY) && $past(st_q) == st_q)
      |-> (row_q == $past(row_q) || row_q == $past(row_q) + 1'b1));
  assert_row_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REC || st_q == ST_PLAY) |-> (row_q <= last_q));
  assert_eom_after_rec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EOM) |-> ($past(st_q) == ST_REC));
  assert_play_no_marker_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(st_q == ST_PLAY) |-> (st_q != ST_EOM));
endmodule

// File: rtl/fm_direct_ctrl.sv
module fm_direct_ctrl #(
  parameter int ROWS    = 128,
  parameter int NUM_MSG = 8,
  parameter int DEB_CYC = 16,
  parameter int ROW_CYC = 4,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int CFG_W  = $clog2(NUM_MSG),
  localparam int CNT_W  = $clog2(NUM_MSG + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic               sel_play_i,
  input  logic [NUM_MSG-1:0] msg_ni,
  output logic [ROW_W-1:0]   row_o,
  output logic               wr_en_o,
  output logic               rd_en_o,
  output logic               eom_wr_o,
  output logic               led_no,
  output logic               pwr_dn_o
);
  logic               loaded_q, play_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ROW_W:0]     len_q;
  logic [NUM_MSG-1:0] clean_n, fall;
  logic               hit;
  logic [CFG_W-1:0]   hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      play_q   <= 1'b0;
      cnt_q    <= CNT_W'(1);
      len_q    <= (ROW_W+1)'(ROWS);
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      play_q   <= sel_play_i;
      cnt_q    <= CNT_W'(int'(cfg_i) + 1);
      len_q    <= (ROW_W+1)'(ROWS / (int'(cfg_i) + 1));
    end
  end

  for (genvar g = 0; g < NUM_MSG; g++) begin : g_deb
    fm_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_ni  (msg_ni[g]),
      .clean_no(clean_n[g]),
      .fall_o  (fall[g])
    );
  end

  fm_msg_pick #(.NUM_MSG(NUM_MSG), .CNT_W(CNT_W), .IDX_W(CFG_W)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fall_i(fall),
    .cnt_i (cnt_q),
    .hit_o (hit),
    .idx_o (hit_idx)
  );

  fm_seq #(.NUM_MSG(NUM_MSG), .ROW_W(ROW_W), .IDX_W(CFG_W), .ROW_CYC(ROW_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (hit && loaded_q),
    .start_idx_i(hit_idx),
    .play_i     (play_q),
    .len_i      (len_q),
    .clean_ni   (clean_n),
    .fall_i     (fall),
    .row_o      (row_o),
    .wr_en_o    (wr_en_o),
    .rd_en_o    (rd_en_o),
    .eom_wr_o   (eom_wr_o),
    .led_no     (led_no),
    .pwr_dn_o   (pwr_dn_o)
  );

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && $past(loaded_q)) |-> ($stable(cnt_q) && $stable(play_q) && $stable(len_q)));
endmodule

// File: tb/sim_fm_direct_ctrl.sv
module sim_fm_direct_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;
  localparam int RC  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg = '0;
  logic       sel = 1'b0;
  logic [7:0] msg_n = 8'hff;
  logic [6:0] row;
  logic       wr_en, rd_en, eom_wr, led_n, pwr_dn;

  int checks = 0, fails = 0, act_cnt = 0, eom_cnt = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_direct_ctrl #(.DEB_CYC(DEB), .ROW_CYC(RC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .sel_play_i(sel), .msg_ni(msg_n),
    .row_o(row), .wr_en_o(wr_en), .rd_en_o(rd_en), .eom_wr_o(eom_wr),
    .led_no(led_n), .pwr_dn_o(pwr_dn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_en || rd_en) act_cnt <= act_cnt + 1;
    if (eom_wr) eom_cnt <= eom_cnt + 1;
  end

  initial begin
    wait (cyc > 150000);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int m_len(int code);
    return 128 / (code + 1);
  endfunction
  function automatic int m_first(int code, int k);
    return (k - 1) * m_len(code);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input int code, input bit s);
    @(negedge clk);
    rst_n = 1'b0;
    msg_n = 8'hff;
    cfg = 3'(code);
    sel = s;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic wait_active(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wr_en || rd_en) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_eom(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (eom_wr) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_play_end(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!rd_en) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    bit ok;
    int a0, e0, code, k, s;
    void'($urandom(32'd4711));

    // R11 reset state
    do_reset(3, 0);
    chk(pwr_dn && !wr_en && !rd_en && !eom_wr && led_n && row == 0, "R11 reset",
        {wr_en, rd_en, eom_wr, led_n, pwr_dn}, 5'b00011);

    // R1 R4 R6: 4 messages, record msg 2 held to the end
    msg_n[1] = 1'b0;
    wait_active(ok);
    chk(ok && wr_en && !led_n && !pwr_dn, "R4 record strobes", {wr_en, led_n, pwr_dn}, 3'b100);
    chk(row == m_first(3, 2), "R1 start row", row, m_first(3, 2));
    wait_eom(ok);
    chk(ok && row == m_first(3, 2) + m_len(3) - 1, "R6 end row", row, m_first(3, 2) + m_len(3) - 1);
    cycles(1);
    chk(pwr_dn && !eom_wr, "R11 idle after marker", pwr_dn, 1);
    msg_n = 8'hff;
    cycles(12);

    // R5 early release
    msg_n[0] = 1'b0;
    wait_active(ok);
    cycles(20);
    msg_n[0] = 1'b1;
    wait_eom(ok);
    chk(ok && row > 0 && row < m_len(3) - 1, "R5 release row", row, 10);
    cycles(2);
    chk(!wr_en && led_n && pwr_dn, "R5 idle after release", wr_en, 0);

    // R3 short glitch
    a0 = act_cnt;
    msg_n[2] = 1'b0;
    cycles(2);
    msg_n[2] = 1'b1;
    cycles(30);
    chk(act_cnt == a0 && pwr_dn, "R3 glitch ignored", act_cnt - a0, 0);

    // R9 input beyond count
    a0 = act_cnt;
    msg_n[5] = 1'b0;
    cycles(40);
    msg_n[5] = 1'b1;
    cycles(12);
    chk(act_cnt == a0 && pwr_dn, "R9 out of range ignored", act_cnt - a0, 0);

    // R2 code/select changed after reset
    cfg = 3'd7;
    sel = 1'b1;
    cycles(3);
    msg_n[3] = 1'b0;
    wait_active(ok);
    chk(ok && wr_en && !rd_en, "R2 select held", rd_en, 0);
    chk(row == m_first(3, 4), "R2 code held", row, m_first(3, 4));
    msg_n = 8'hff;
    wait_eom(ok);
    cycles(12);

    // R10 priority, R8 toggle stop: 3 messages, playback
    do_reset(2, 1);
    msg_n[1] = 1'b0;
    msg_n[2] = 1'b0;
    wait_active(ok);
    chk(ok && rd_en && row == m_first(2, 2), "R10 lowest wins", row, m_first(2, 2));
    msg_n = 8'hff;
    cycles(8);
    msg_n[0] = 1'b0;
    cycles(8);
    msg_n[0] = 1'b1;
    cycles(8);
    chk(rd_en && row >= m_first(2, 2) && row < m_first(2, 3), "R10 others ignored", row, m_first(2, 2));
    msg_n[1] = 1'b0;
    cycles(DEB + 6);
    chk(!rd_en && pwr_dn, "R8 toggle stop", rd_en, 0);
    msg_n = 8'hff;
    cycles(12);

    // R7 natural end of last message, leftover rows unused
    e0 = eom_cnt;
    msg_n[2] = 1'b0;
    wait_active(ok);
    chk(ok && rd_en && led_n, "R7 play strobes", rd_en, 1);
    cycles(8);
    msg_n = 8'hff;
    wait_play_end(ok);
    chk(ok && row == m_first(2, 3) + m_len(2) - 1, "R7 R1 play end row", row, m_first(2, 3) + m_len(2) - 1);
    chk(eom_cnt == e0, "R7 no marker", eom_cnt - e0, 0);
    cycles(12);

    // random trials
    for (int t = 0; t < 14; t++) begin
      code = int'($urandom_range(7, 0));
      s = int'($urandom_range(1, 0));
      k = int'($urandom_range(code + 1, 1));
      do_reset(code, s[0]);
      e0 = eom_cnt;
      msg_n[k-1] = 1'b0;
      wait_active(ok);
      chk(ok && row == m_first(code, k), "R1 rand start", row, m_first(code, k));
      if (s == 0) begin
        chk(wr_en && !led_n, "R4 rand record", wr_en, 1);
        wait_eom(ok);
        chk(ok && row == m_first(code, k) + m_len(code) - 1, "R6 rand end", row, m_first(code, k) + m_len(code) - 1);
        msg_n = 8'hff;
      end else begin
        chk(rd_en, "R7 rand play", rd_en, 1);
        cycles(8);
        msg_n = 8'hff;
        wait_play_end(ok);
        chk(ok && row == m_first(code, k) + m_len(code) - 1 && eom_cnt == e0, "R7 rand end",
            row, m_first(code, k) + m_len(code) - 1);
      end
      cycles(12);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule